// File: doc/BRIEF.md
# Clock-Sampled Pseudo-Static RAM Emulator

This block stands in for a 16-bit asynchronous pseudo-static RAM on the memory side of a controller under test. Each rising clock edge samples two opposite-polarity chip selects, an active-low output enable, an active-low write strobe, two active-low byte-lane enables, a word address and the write data. From these samples the block works out whether the device is selected, reading, writing or in standby. It stores data one byte lane at a time and decides, lane by lane, whether the bidirectional data bus is driven.

The data bus is split into an input, an output and a per-lane output enable. The pad logic around the block joins them into the shared bus. Analog behaviour and nanosecond timing are not modelled. The only timing is a read latency, set in clock cycles by a parameter. The address port is 17 bits wide to match a 128K-word part. The storage behind it is sized by a separate parameter so that smaller builds can be made, and address bits above that size alias.

Top module: `psram_emu`

## Requirements
- R1: The device counts as selected only when the sampled `ce1N` is 0 and `ce2` is 1. With any other pair of values, reads and writes have no effect and no lane is driven.
- R2: `standby` is 1 whenever the device is not selected, or when `bleN` and `bheN` are both 1. Otherwise it is 0.
- R3: During a read (selected, `oeN` 0, `weN` 1), `dataOe[0]` drives bits 7:0 when `bleN` is 0, and `dataOe[1]` drives bits 15:8 when `bheN` is 0. `dataOut` carries the stored word on the enabled lanes.
- R4: `dataOe` is 0 when the device is deselected, when `oeN` is 1, or while a write is in progress (selected with `weN` 0).
- R5: A write window is open only while the device is selected, `weN` is 0 and at least one byte enable is 0. A window closes when any one of these stops holding. A write attempted while deselected, or with both byte enables at 1, leaves the memory unchanged.
- R6: When a window closes, the memory takes the data and address sampled in the last cycle of the window. Only the lanes whose enable was 0 in that cycle are written. The write lands on the second rising edge after the last sample that had the window open.
- R7: The lanes are driven only after `READ_LAT` rising edges (minimum 1) have followed the edge that first sampled the read condition. An address change restarts this count. `dataOe` falls after the first edge that samples the read condition as false.
- R8: All pins are sampled on the rising edge of `clk`. After reset (`rst_n` 0), `dataOe` is 0 and `standby` is 1.
- R9: The storage holds 2^`STORE_AW` words. Address bits at and above `STORE_AW` are ignored, so addresses that differ only in those bits reach the same word.
- R10: A read whose condition becomes true on the same sample that closes a write window returns the newly written data once its latency has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce1N | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| bleN | input | 1 | Active-low enable for bits 7:0 |
| bheN | input | 1 | Active-low enable for bits 15:8 |
| addr | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data toward the bus |
| dataOe | output | 2 | Per-lane drive enable, bit 0 for bits 7:0 |
| standby | output | 1 | High while the standby condition holds |

## Verification
A write can commit to memory in the same cycle that a read of that address starts. This happens when the write strobe rises while the output enable is already low. The bench provokes this by holding `oeN` at 0 through a write and then raising `weN` alone. It expects no lane drive until the read latency has run out, and then the fresh word, not the old one. A second overlap happens when an address change lands on a read that is already running. The bench expects the drive to drop for one latency period and then return with the new word.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef struct packed {
    logic             capture;  // write window open on this sample
    logic             commit;   // window just closed, write pending word
    logic [LANES-1:0] wrLanes;  // lanes enabled on this sample
    logic [LANES-1:0] laneOe;   // lanes to drive
  } strobe_t;
endpackage

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic [LANES-1:0]  benN,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sAddr,
  output strobe_t           strobes,
  output logic              standby
);
  localparam int CNT_W = $clog2(READ_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(READ_LAT);

  logic              sCe1n, sCe2, sOen, sWen;
  logic [LANES-1:0]  sBen;
  logic [ADDR_W-1:0] lastAddr;
  logic [CNT_W-1:0]  latCnt;
  logic              pendValid;
  logic              selected, anyLane, wrAct, rdCond, addrMoved, dataReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sCe1n    <= 1'b1;
      sCe2     <= 1'b0;
      sOen     <= 1'b1;
      sWen     <= 1'b1;
      sBen     <= '1;
      sAddr    <= '0;
      lastAddr <= '0;
    end else begin
      sCe1n    <= ce1N;
      sCe2     <= ce2;
      sOen     <= oeN;
      sWen     <= weN;
      sBen     <= benN;
      sAddr    <= addr;
      lastAddr <= sAddr;
    end
  end

  assign selected  = ~sCe1n & sCe2;
  assign anyLane   = ~(&sBen);
  assign wrAct     = selected & ~sWen & anyLane;
  assign rdCond    = selected & ~sOen & sWen;
  assign addrMoved = (sAddr != lastAddr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latCnt    <= '0;
      pendValid <= 1'b0;
    end else begin
      pendValid <= wrAct;
      if (!rdCond)             latCnt <= '0;
      else if (addrMoved)      latCnt <= CNT_W'(1);
      else if (latCnt < LAT_C) latCnt <= latCnt + 1'b1;
    end
  end

  assign dataReady       = rdCond & ~addrMoved & (latCnt >= LAT_C);
  assign strobes.capture = wrAct;
  assign strobes.commit  = pendValid & ~wrAct;
  assign strobes.wrLanes = ~sBen;
  assign strobes.laneOe  = dataReady ? ~sBen : '0;
  assign standby         = ~selected | (&sBen);

  AST_NO_DRIVE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (strobes.laneOe == '0)); // R2
  AST_NO_DRIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |-> (strobes.laneOe == '0)); // R4
  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.laneOe != '0) |-> $past(rdCond)); // R7
endmodule

// File: rtl/psram_dpath.sv
`timescale 1ns/1ps
module psram_dpath
  import psram_pkg::*;
#(
  parameter int STORE_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strobes,
  input  logic [STORE_AW-1:0] rdAddr,
  input  logic [WORD_W-1:0]   dataIn,
  output logic [WORD_W-1:0]   dataOut
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [WORD_W-1:0]   memArr [DEPTH];
  logic [WORD_W-1:0]   sDin, pData;
  logic [STORE_AW-1:0] pAddr;
  logic [LANES-1:0]    pMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sDin  <= '0;
      pData <= '0;
      pAddr <= '0;
      pMask <= '0;
    end else begin
      sDin <= dataIn;
      if (strobes.capture) begin
        pData <= sDin;
        pAddr <= rdAddr;
        pMask <= strobes.wrLanes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      for (int ln = 0; ln < LANES; ln++) begin
        if (pMask[ln]) memArr[pAddr][ln*LANE_W +: LANE_W] <= pData[ln*LANE_W +: LANE_W];
      end
    end
  end

  assign dataOut = memArr[rdAddr];

  AST_COMMIT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.commit |-> $past(strobes.capture)); // R6
  AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.commit |-> (pMask != '0)); // R5
endmodule

// File: rtl/psram_emu.sv
`timescale 1ns/1ps
module psram_emu
  import psram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int STORE_AW = 10,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic              bleN,
  input  logic              bheN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        dataOe,
  output logic              standby
);
  strobe_t           strobes;
  logic [ADDR_W-1:0] sAddr;

  psram_ctrl #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN),
    .benN({bheN, bleN}), .addr(addr), .sAddr(sAddr), .strobes(strobes),
    .standby(standby)
  );

  psram_dpath #(.STORE_AW(STORE_AW)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rdAddr(sAddr[STORE_AW-1:0]),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  assign dataOe = strobes.laneOe;

  AST_HIZ_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1N && ce2 && !weN) |=> (dataOe == 2'b00)); // R4
endmodule

// File: tb/psram_emu_tb.sv
`timescale 1ns/1ps
module psram_emu_tb_top;
  localparam int AW = 17;
  localparam int SAW = 4;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1N, ce2, oeN, weN, bleN, bheN;
  logic [AW-1:0] addr;
  logic [15:0] dataIn, dataOut;
  logic [1:0] dataOe;
  logic standby;
  int nChecks = 0, nFail = 0;
  logic [15:0] model [1 << SAW];

  always #2.5 clk = ~clk;

  psram_emu #(.ADDR_W(AW), .STORE_AW(SAW), .READ_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN),
    .bleN(bleN), .bheN(bheN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .standby(standby)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'hA5C3 ^ 16'(a * 16'h1111) ^ 16'(a << 9);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    ce1N = 1'b1; ce2 = 1'b0; oeN = 1'b1; weN = 1'b1; bleN = 1'b1; bheN = 1'b1;
  endtask

  // single-cycle write window, closed by WE# rising
  task automatic wr(input int a, input logic [15:0] d, input logic bl, input logic bh,
                    input logic keepOe);
    ce1N = 1'b0; ce2 = 1'b1; weN = 1'b0; oeN = keepOe ? 1'b0 : 1'b1;
    bleN = bl; bheN = bh; addr = AW'(a); dataIn = d;
    step();
    chk("R4 no drive in write", 32'(dataOe), 32'h0);
    if (!keepOe) begin
      idle(); step(); step(); step();
    end
  endtask

  task automatic rd(input int a, input logic bl, input logic bh, input logic [15:0] exp,
                    input string req);
    logic [1:0] eo;
    logic [15:0] m;
    eo = {~bh, ~bl};
    m = {{8{eo[1]}}, {8{eo[0]}}};
    ce1N = 1'b0; ce2 = 1'b1; weN = 1'b1; oeN = 1'b0; bleN = bl; bheN = bh; addr = AW'(a);
    for (int i = 0; i <= LAT; i++) begin
      step();
      if (i < LAT) chk({req, " R7 latency hold-off"}, 32'(dataOe), 32'h0);
      else chk({req, " R3 lanes"}, 32'(dataOe), 32'(eo));
    end
    chk({req, " R3 data"}, 32'(dataOut & m), 32'(exp & m));
    idle(); step();
    chk("R7 drop on read end", 32'(dataOe), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    idle(); addr = '0; dataIn = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R8 reset drive", 32'(dataOe), 32'h0);
    chk("R8 reset standby", 32'(standby), 32'h1);

    // R1 R2 standby sweep
    for (int v = 0; v < 16; v++) begin
      ce1N = v[0]; ce2 = v[1]; bleN = v[2]; bheN = v[3]; oeN = 1'b1; weN = 1'b1;
      step();
      chk("R2 standby", 32'(standby), 32'(!(!v[0] && v[1]) || (v[2] && v[3])));
    end
    idle(); step();

    // R5 R6 fill, R3 R9 read back
    for (int a = 0; a < (1 << SAW); a++) begin
      wr(a, pat(a), 1'b0, 1'b0, 1'b0);
      model[a] = pat(a);
    end
    for (int a = 0; a < (1 << SAW); a++) rd(a, 1'b0, 1'b0, model[a], "R6 fill");

    // R3 single lanes
    rd(5, 1'b1, 1'b0, model[5], "R3 high lane");
    rd(5, 1'b0, 1'b1, model[5], "R3 low lane");

    // R6 low lane write only
    wr(3, 16'h1234, 1'b0, 1'b1, 1'b0);
    model[3] = {model[3][15:8], 8'h34};
    rd(3, 1'b0, 1'b0, model[3], "R6 lane mask");

    // R1 R5 writes with no effect
    ce1N = 1'b0; ce2 = 1'b0; weN = 1'b0; oeN = 1'b1; bleN = 1'b0; bheN = 1'b0;
    addr = AW'(4); dataIn = 16'hDEAD; step(); idle(); step(); step();
    ce1N = 1'b1; ce2 = 1'b1; weN = 1'b0; bleN = 1'b0; bheN = 1'b0; step(); idle(); step(); step();
    rd(4, 1'b0, 1'b0, model[4], "R1 deselected write ignored");
    wr(6, 16'hFACE, 1'b1, 1'b1, 1'b0);
    rd(6, 1'b0, 1'b0, model[6], "R5 no-lane write ignored");

    // R6 multi-cycle window, last data and last mask win, closed by CE1#
    ce1N = 1'b0; ce2 = 1'b1; weN = 1'b0; oeN = 1'b1; addr = AW'(7);
    bleN = 1'b0; bheN = 1'b0; dataIn = 16'h1111; step();
    dataIn = 16'h2222; step();
    bleN = 1'b1; dataIn = 16'h9A33; step();
    ce1N = 1'b1; step(); idle(); step(); step();
    model[7] = {8'h9A, model[7][7:0]};
    rd(7, 1'b0, 1'b0, model[7], "R6 last sample");

    // R4 no drive cases
    ce1N = 1'b0; ce2 = 1'b1; oeN = 1'b0; weN = 1'b0; bleN = 1'b1; bheN = 1'b1; addr = AW'(2);
    repeat (LAT + 2) step();
    chk("R4 WE low with no lane", 32'(dataOe), 32'h0);
    oeN = 1'b1; weN = 1'b1; bleN = 1'b0; bheN = 1'b0;
    repeat (LAT + 2) step();
    chk("R4 OE high", 32'(dataOe), 32'h0);
    ce1N = 1'b1; oeN = 1'b0;
    repeat (LAT + 2) step();
    chk("R4 deselected", 32'(dataOe), 32'h0);
    idle(); step();

    // R9 alias
    wr((1 << SAW) + 9, 16'h0BAD, 1'b0, 1'b0, 1'b0);
    model[9] = 16'h0BAD;
    rd(9, 1'b0, 1'b0, model[9], "R9 alias");

    // R7 address change restarts latency
    ce1N = 1'b0; ce2 = 1'b1; weN = 1'b1; oeN = 1'b0; bleN = 1'b0; bheN = 1'b0; addr = AW'(2);
    repeat (LAT + 1) step();
    chk("R7 first address", 32'(dataOut), 32'(model[2]));
    addr = AW'(10);
    for (int i = 0; i <= LAT; i++) begin
      step();
      if (i < LAT) chk("R7 restart hold-off", 32'(dataOe), 32'h0);
      else chk("R7 restart drive", 32'(dataOe), 32'h3);
    end
    chk("R7 new address data", 32'(dataOut), 32'(model[10]));
    idle(); step();

    // R10 read starts on the sample that closes the write
    wr(11, 16'hBEEF, 1'b0, 1'b0, 1'b1);
    model[11] = 16'hBEEF;
    rd(11, 1'b0, 1'b0, model[11], "R10 write-to-read");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule